// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is a byte-wide, two-way mailbox between a host bus and a local microcontroller, laid out like the classic PC keyboard-controller interface. The host puts a byte into an inbound buffer through either a data port or a command port. The local CPU puts a byte into an outbound buffer for the host to collect. An 8-bit status word tells both sides which buffers hold unread bytes and which port the host used last. The local CPU can also write a few free-use bits in that word. The host can only read them.

Each buffer is controlled by a two-state machine with the states `BUF_EMPTY` and `BUF_FULL`. The inbound machine takes `host_write` (EMPTY→FULL, or FULL→FULL when the host overwrites an unread byte) and `local_read` (FULL→EMPTY). The outbound machine takes `local_write` (EMPTY→FULL, FULL→FULL) and `host_read` (FULL→EMPTY). If a write and a clearing read reach the same buffer in the same cycle, the write wins. Every host write also produces a one-cycle event. That event can drive the local interrupt for a full input buffer and can also wake the local CPU from a low-power halt. A separate keyboard interrupt output is raised when the local CPU posts a byte, but only while the interrupt is enabled.

All access strobes are single-cycle and are sampled on the rising clock edge. Read data is combinational from the addressed register.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset the status word is 0x00 and both `kirq` and `ibf_event` are low.
- R2: A host write with `host_cmd`=0 stores `host_wdata` in the inbound buffer, sets status bit 1 (input full) and clears status bit 3 (command tag).
- R3: A host write with `host_cmd`=1 stores the byte, sets status bit 1 and sets status bit 3.
- R4: A local read with `loc_sel_status`=0 returns the inbound byte on `loc_rdata` and clears status bit 1. It leaves bit 3 unchanged.
- R5: A local write with `loc_sel_status`=0 loads the outbound buffer and sets status bit 0 (output full). A host read with `host_cmd`=0 returns that byte on `host_rdata` and clears bit 0.
- R6: `kirq` rises with the local data write when `kirq_en`=1 and falls with the host data read. A local data write made while `kirq_en`=0 leaves `kirq` low.
- R7: Status layout is bit 0 output full, bit 1 input full, bit 2 free-use, bit 3 command tag, bits 7..4 free-use. A host read with `host_cmd`=1 and a local read with `loc_sel_status`=1 both return this word and change nothing.
- R8: A local write with `loc_sel_status`=1 updates only bits 2 and 7..4 from `loc_wdata`. Bits 0, 1 and 3 keep their values.
- R9: `ibf_event` is high for exactly the one cycle after each host write. This includes writes that overwrite an unread byte.
- R10: A host write to a full inbound buffer replaces the stored byte and bit 1 stays set.
- R11: A write and a clearing read that hit the same buffer in the same cycle leave that buffer full. The read returns the old byte and the buffer then holds the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_cmd | input | 1 | Host port select: 1 command/status, 0 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status word when `host_cmd`=1, outbound byte otherwise |
| loc_wr | input | 1 | Local CPU write strobe |
| loc_rd | input | 1 | Local CPU read strobe |
| loc_sel_status | input | 1 | Local register select: 1 status, 0 data |
| loc_wdata | input | 8 | Local write byte |
| loc_rdata | output | 8 | Status word when `loc_sel_status`=1, inbound byte otherwise |
| kirq_en | input | 1 | Enable for the keyboard interrupt |
| kirq | output | 1 | Keyboard interrupt request |
| ibf_event | output | 1 | One-cycle pulse after each host write |

## Verification
Every flag, stored byte, free-use bit and `kirq` changes on the rising edge that samples the strobe, so these results are due one cycle after the stimulus. `ibf_event` is registered and is high in that same following cycle only. Read data is combinational, so it is due during the strobe cycle itself. The bench drives each strobe at a falling edge and captures read data just before the next rising edge. It then samples the status word and `kirq` at the falling edge after that rising edge. It checks `ibf_event` in that cycle and again one cycle later to confirm the pulse is only one cycle wide.

// File: rtl/kbc_mailbox_pkg.sv
package kbc_mailbox_pkg;

    localparam int BYTE_W     = 8;
    localparam int OBF_BIT    = 0;
    localparam int IBF_BIT    = 1;
    localparam int CD_BIT     = 3;
    localparam logic [BYTE_W-1:0] FLAG_MASK =
        BYTE_W'((1 << OBF_BIT) | (1 << IBF_BIT) | (1 << CD_BIT));
    localparam logic [BYTE_W-1:0] UD_MASK = ~FLAG_MASK;

    typedef enum logic {
        BUF_EMPTY = 1'b0,
        BUF_FULL  = 1'b1
    } buf_state_e;

endpackage

// File: rtl/kbc_inbox.sv
module kbc_inbox
    import kbc_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              cmd_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] data_q,
    output logic              full,
    output logic              cmd_tag,
    output logic              wr_event
);

    buf_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUF_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: if (wr_stb)            state_d = BUF_FULL;
            BUF_FULL:  if (rd_stb && !wr_stb) state_d = BUF_EMPTY;
            default:                          state_d = BUF_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            cmd_tag  <= 1'b0;
            wr_event <= 1'b0;
        end else begin
            wr_event <= wr_stb;
            if (wr_stb) begin
                data_q  <= wdata;
                cmd_tag <= cmd_sel;
            end
        end
    end

    always_comb full = (state_q == BUF_FULL);

endmodule

// File: rtl/kbc_outbox.sv
module kbc_outbox
    import kbc_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_stb,
    input  logic              irq_en,
    output logic [BYTE_W-1:0] data_q,
    output logic              full,
    output logic              irq
);

    buf_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUF_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: if (wr_stb)            state_d = BUF_FULL;
            BUF_FULL:  if (rd_stb && !wr_stb) state_d = BUF_EMPTY;
            default:                          state_d = BUF_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            irq    <= 1'b0;
        end else begin
            if (wr_stb) data_q <= wdata;
            if (wr_stb && irq_en) irq <= 1'b1;
            else if (rd_stb)      irq <= 1'b0;
        end
    end

    always_comb full = (state_q == BUF_FULL);

endmodule

// File: rtl/kbc_status_ud.sv
module kbc_status_ud
    import kbc_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ud_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)      ud_q <= '0;
        else if (wr_stb) ud_q <= wdata & UD_MASK;
    end

endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
    import kbc_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_cmd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              loc_wr,
    input  logic              loc_rd,
    input  logic              loc_sel_status,
    input  logic [BYTE_W-1:0] loc_wdata,
    output logic [BYTE_W-1:0] loc_rdata,
    input  logic              kirq_en,
    output logic              kirq,
    output logic              ibf_event
);

    logic              loc_data_rd, loc_data_wr, loc_stat_wr, host_data_rd;
    logic [BYTE_W-1:0] in_byte, out_byte, ud_bits, status_word;
    logic              ibf, obf, cd_tag;

    always_comb begin
        loc_data_rd  = loc_rd && !loc_sel_status;
        loc_data_wr  = loc_wr && !loc_sel_status;
        loc_stat_wr  = loc_wr &&  loc_sel_status;
        host_data_rd = host_rd && !host_cmd;
    end

    kbc_inbox u_inbox (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (host_wr),
        .cmd_sel  (host_cmd),
        .wdata    (host_wdata),
        .rd_stb   (loc_data_rd),
        .data_q   (in_byte),
        .full     (ibf),
        .cmd_tag  (cd_tag),
        .wr_event (ibf_event)
    );

    kbc_outbox u_outbox (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (loc_data_wr),
        .wdata  (loc_wdata),
        .rd_stb (host_data_rd),
        .irq_en (kirq_en),
        .data_q (out_byte),
        .full   (obf),
        .irq    (kirq)
    );

    kbc_status_ud u_ud (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (loc_stat_wr),
        .wdata  (loc_wdata),
        .ud_q   (ud_bits)
    );

    always_comb begin
        status_word          = ud_bits & UD_MASK;
        status_word[OBF_BIT] = obf;
        status_word[IBF_BIT] = ibf;
        status_word[CD_BIT]  = cd_tag;
    end

    always_comb begin
        host_rdata = host_cmd       ? status_word : out_byte;
        loc_rdata  = loc_sel_status ? status_word : in_byte;
    end

endmodule

// File: rtl/kbc_mailbox_chk.sv
module kbc_mailbox_chk
    import kbc_mailbox_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic              host_cmd,
    input logic              loc_wr,
    input logic              loc_rd,
    input logic              loc_sel_status,
    input logic              kirq,
    input logic              ibf_event,
    input logic [BYTE_W-1:0] status_word
);

    logic data_touch;
    always_comb data_touch = host_wr || (host_rd && !host_cmd) ||
                             (loc_rd && !loc_sel_status) || (loc_wr && !loc_sel_status);

    a_r2_data_wr_sets_ibf: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && !host_cmd |=> status_word[IBF_BIT] && !status_word[CD_BIT]);

    a_r3_cmd_wr_sets_tag: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_cmd |=> status_word[IBF_BIT] && status_word[CD_BIT]);

    a_r4_local_rd_clears_ibf: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rd && !loc_sel_status && !host_wr |=> !status_word[IBF_BIT]);

    a_r5_local_wr_sets_obf: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wr && !loc_sel_status |=> status_word[OBF_BIT]);

    a_r6_kirq_needs_obf: assert property (@(posedge clk) disable iff (!rst_n)
        kirq |-> status_word[OBF_BIT]);

    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !data_touch |=> (status_word & FLAG_MASK) == $past(status_word & FLAG_MASK));

    a_r9_event_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> ibf_event);

    a_r9_event_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> !ibf_event);

endmodule

bind kbc_mailbox kbc_mailbox_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_wr        (host_wr),
    .host_rd        (host_rd),
    .host_cmd       (host_cmd),
    .loc_wr         (loc_wr),
    .loc_rd         (loc_rd),
    .loc_sel_status (loc_sel_status),
    .kirq           (kirq),
    .ibf_event      (ibf_event),
    .status_word    (status_word)
);

// File: tb/test_kbc_mailbox.sv
module test_kbc_mailbox;

    localparam logic [3:0] OP_HWD = 4'd0; // host write data port
    localparam logic [3:0] OP_HWC = 4'd1; // host write command port
    localparam logic [3:0] OP_HRD = 4'd2; // host read data
    localparam logic [3:0] OP_HRS = 4'd3; // host read status
    localparam logic [3:0] OP_LWD = 4'd4; // local write data
    localparam logic [3:0] OP_LWS = 4'd5; // local write status
    localparam logic [3:0] OP_LRD = 4'd6; // local read data
    localparam logic [3:0] OP_LRS = 4'd7; // local read status
    localparam int NVEC = 14;

    // {op, wdata, expected read byte, expected status after, expected kirq after}
    localparam logic [28:0] VEC [NVEC] = '{
        {OP_HRS, 8'h00, 8'h00, 8'h00, 1'b0},
        {OP_HWD, 8'h5A, 8'h00, 8'h02, 1'b0},
        {OP_LRS, 8'h00, 8'h02, 8'h02, 1'b0},
        {OP_LRD, 8'h00, 8'h5A, 8'h00, 1'b0},
        {OP_HWC, 8'hAD, 8'h00, 8'h0A, 1'b0},
        {OP_LRD, 8'h00, 8'hAD, 8'h08, 1'b0},
        {OP_LWD, 8'h3C, 8'h00, 8'h09, 1'b1},
        {OP_HRS, 8'h00, 8'h09, 8'h09, 1'b1},
        {OP_HRD, 8'h00, 8'h3C, 8'h08, 1'b0},
        {OP_LWS, 8'hFF, 8'h00, 8'hFC, 1'b0},
        {OP_LWS, 8'h03, 8'h00, 8'h08, 1'b0},
        {OP_HWD, 8'h11, 8'h00, 8'h02, 1'b0},
        {OP_HWD, 8'h22, 8'h00, 8'h02, 1'b0},
        {OP_LRD, 8'h00, 8'h22, 8'h00, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_cmd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       loc_wr = 1'b0, loc_rd = 1'b0, loc_sel_status = 1'b0;
    logic [7:0] loc_wdata = '0, loc_rdata;
    logic       kirq_en = 1'b1, kirq, ibf_event;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    kbc_mailbox i_kbc_mailbox (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_cmd(host_cmd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_sel_status(loc_sel_status),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .kirq_en(kirq_en), .kirq(kirq), .ibf_event(ibf_event)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_wr = 0; host_rd = 0; loc_wr = 0; loc_rd = 0;
        host_cmd = 1; loc_sel_status = 1;
    endtask

    function automatic logic [7:0] status_now();
        return loc_rdata; // loc_sel_status held at 1 while idle
    endfunction

    // caller is at a falling edge; returns at the falling edge after the update
    task automatic do_op(input logic [3:0] op, input logic [7:0] wd, output logic [7:0] rd);
        idle();
        unique case (op)
            OP_HWD: begin host_wr = 1; host_cmd = 0; host_wdata = wd; end
            OP_HWC: begin host_wr = 1; host_cmd = 1; host_wdata = wd; end
            OP_HRD: begin host_rd = 1; host_cmd = 0; end
            OP_HRS: begin host_rd = 1; host_cmd = 1; end
            OP_LWD: begin loc_wr = 1; loc_sel_status = 0; loc_wdata = wd; end
            OP_LWS: begin loc_wr = 1; loc_sel_status = 1; loc_wdata = wd; end
            OP_LRD: begin loc_rd = 1; loc_sel_status = 0; end
            OP_LRS: begin loc_rd = 1; loc_sel_status = 1; end
            default: ;
        endcase
        #1;
        rd = (op == OP_HRD || op == OP_HRS) ? host_rdata : loc_rdata;
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic       ev1;
        do_reset();
        // R1 reset state
        check("R1 status", status_now(), 8'h00);
        check("R1 kirq", {7'd0, kirq}, 8'h00);
        check("R1 ibf_event", {7'd0, ibf_event}, 8'h00);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0] op;
            op = VEC[i][28:25];
            do_op(op, VEC[i][24:17], rd);
            if (op == OP_HRD || op == OP_HRS || op == OP_LRD || op == OP_LRS)
                check($sformatf("R4/R5/R7 vec%0d read", i), rd, VEC[i][16:9]);
            check($sformatf("R2/R3/R8/R10 vec%0d status", i), status_now(), VEC[i][8:1]);
            check($sformatf("R6 vec%0d kirq", i), {7'd0, kirq}, {7'd0, VEC[i][0]});
        end

        // R9: pulse one cycle after a host write, also on overwrite
        do_op(OP_HWD, 8'h41, rd);
        ev1 = ibf_event;
        check("R9 event after write", {7'd0, ev1}, 8'h01);
        @(negedge clk); #1;
        check("R9 event one cycle", {7'd0, ibf_event}, 8'h00);
        do_op(OP_HWC, 8'h42, rd);
        check("R9 event on overwrite", {7'd0, ibf_event}, 8'h01);
        check("R10 overwrite flags", status_now(), 8'h0A);

        // R11: host write and local data read in same cycle
        idle();
        host_wr = 1; host_cmd = 0; host_wdata = 8'h77;
        loc_rd = 1; loc_sel_status = 0;
        #1; rd = loc_rdata;
        @(negedge clk); idle(); #1;
        check("R11 inbound read old byte", rd, 8'h42);
        check("R11 inbound stays full", status_now(), 8'h02);
        do_op(OP_LRD, 8'h00, rd);
        check("R11 inbound new byte", rd, 8'h77);

        // R6: no interrupt when disabled
        kirq_en = 0;
        do_op(OP_LWD, 8'h99, rd);
        check("R6 kirq disabled", {7'd0, kirq}, 8'h00);
        check("R5 obf set while disabled", status_now(), 8'h01);
        do_op(OP_HRD, 8'h00, rd);
        check("R5 host data read", rd, 8'h99);

        // R11: local data write and host data read in same cycle
        kirq_en = 1;
        do_op(OP_LWD, 8'h10, rd);
        idle();
        loc_wr = 1; loc_sel_status = 0; loc_wdata = 8'h20;
        host_rd = 1; host_cmd = 0;
        #1; rd = host_rdata;
        @(negedge clk); idle(); #1;
        check("R11 outbound read old byte", rd, 8'h10);
        check("R11 outbound stays full", status_now(), 8'h01);
        check("R11 kirq stays", {7'd0, kirq}, 8'h01);
        do_op(OP_HRD, 8'h00, rd);
        check("R11 outbound new byte", rd, 8'h20);

        // R8: local status write cannot raise flags
        do_op(OP_LWS, 8'h0B, rd);
        check("R8 flags untouched", status_now(), 8'h00);

        // R1 again: reset from a busy state
        do_op(OP_HWC, 8'h01, rd);
        do_op(OP_LWD, 8'h02, rd);
        do_op(OP_LWS, 8'hF4, rd);
        do_reset();
        check("R1 status after busy reset", status_now(), 8'h00);
        check("R1 kirq after busy reset", {7'd0, kirq}, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule